// File: doc/BRIEF.md
# Multi-Beat Command Front End with Result Buffer

This block is the slave side of a search engine that hangs on a synchronous SRAM-style bus with pipelined reads. The host builds each command out of ordinary write cycles. The write address names a context. The first beat's low bits name the operation, and a small per-operation table sets how many beats the command takes. When the last beat lands, the block packs the beats into one request and hands it to the downstream lookup pipeline through a valid/ready pair. If the pipeline is stalled, a one-deep skid register holds one more request and a busy flag tells the host to pause.

The downstream pipeline returns results word by word into a slot tied to the context. Writing the final word of a slot raises that context's done flag. The host fetches result words, or a status word that holds all done flags, with plain read cycles of fixed latency. Reading the final word of a slot clears its done flag. Several contexts can be in flight at once, and their beats can be interleaved freely.

The address is `{space, ctx, word}`. With the defaults that is 4 bits: bit 3 is space, bits 2:1 are ctx, and bit 0 is word. The number of contexts and the number of words per slot must be powers of two.

Top module: `cmdbuf_front`

## Requirements
- R1: After reset, `req_valid`, `busy` and `bus_rvalid` are 0 and `bus_rdata` is 0. A status read returns 0.
- R2: Bits 1:0 of the first beat of a context give the operation code. The default table needs code+1 beats (1 to 4). Exactly one request is issued once all beats have arrived. It carries `req_op`, `req_ctx` and `req_data`, with beat k in bits [32k+31:32k] and unused lanes set to zero.
- R3: `req_valid` rises on the clock edge that accepts the final beat, and is still 0 after a non-final beat.
- R4: Beats for different contexts may interleave and are assembled separately. Writes with the space bit set are ignored.
- R5: While `req_valid` is high and `req_ready` is low, the request fields stay unchanged.
- R6: A command that completes while a request is stalled goes to the skid register and raises `busy`. It is presented after the stalled request is taken, in completion order.
- R7: Every write while `busy` is high is ignored. It neither counts as a beat nor issues a request.
- R8: `res_we` stores `res_data` at (`res_ctx`, `res_word`). A read with the space bit clear returns that word. The data and `bus_rvalid` appear on the second rising edge after the edge that captures the read address, and `bus_rvalid` is 0 between those edges.
- R9: A result write to the last word of a slot sets that context's done flag. A read with the space bit set returns the done flags in bits NCTX-1:0.
- R10: Reading the last word of a slot clears its done flag. Reading any other word of the slot does not.
- R11: If a read of a slot's last word and a result write to that same word fall on one edge, the read returns the old word and the done flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_addr | input | 4 | Address {space, ctx, word} |
| bus_wdata | input | 32 | Write beat |
| bus_rdata | output | 32 | Read data, zero when not valid |
| bus_rvalid | output | 1 | Read data valid |
| req_valid | output | 1 | Request to the pipeline is valid |
| req_ready | input | 1 | Pipeline accepts the request |
| req_op | output | 2 | Operation code of the request |
| req_ctx | output | 2 | Context of the request |
| req_data | output | 128 | Packed beats of the request |
| busy | output | 1 | Skid register occupied; host writes are dropped |
| res_we | input | 1 | Pipeline result write strobe |
| res_ctx | input | 2 | Result slot |
| res_word | input | 1 | Word inside the slot |
| res_data | input | 32 | Result word |

## Verification
The host's read of a slot's last word and the pipeline's write of that same word can land on one clock edge. One clears the done flag and the other sets it. The bench forces this by driving `bus_re` and `res_we` to the same context and word in one cycle. It then checks that the read returns the earlier word, and that a status read still shows the flag set. A second pair is a command completing while the output is stalled; the bench holds `req_ready` low to push the new command into the skid register, and checks the order of the later handshakes and that writes made during `busy` are dropped.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    typedef enum logic {
        SPACE_SLOT   = 1'b0,
        SPACE_STATUS = 1'b1
    } space_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cmdbuf_assembler.sv
module cmdbuf_assembler #(
    parameter int NCTX  = 4,
    parameter int DW    = 32,
    parameter int MAXB  = 4,
    parameter int OPC_W = 2,
    parameter int CTX_W = 2,
    parameter int BCW   = 3,
    parameter logic [(2**OPC_W)*BCW-1:0] BEAT_TABLE = {3'd4, 3'd3, 3'd2, 3'd1}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CTX_W-1:0]     wr_ctx,
    input  logic [DW-1:0]        wr_data,
    output logic                 cmp_v,
    output logic [OPC_W-1:0]     cmp_op,
    output logic [CTX_W-1:0]     cmp_ctx,
    output logic [MAXB*DW-1:0]   cmp_data
);
    localparam int BIDX_W = cmdbuf_pkg::idx_width(MAXB);

    typedef struct {
        logic [BCW-1:0]   cnt  [NCTX];
        logic [BCW-1:0]   need [NCTX];
        logic [OPC_W-1:0] op   [NCTX];
        logic [DW-1:0]    beat [NCTX][MAXB];
    } asm_st_t;

    asm_st_t st_q, st_d;

    logic [BCW-1:0]   idx_d;
    logic [BCW-1:0]   nxt_d;
    logic [BCW-1:0]   need_d;
    logic [OPC_W-1:0] op_d;

    function automatic logic [BCW-1:0] lookup_need(input logic [OPC_W-1:0] op);
        logic [BCW-1:0] n;
        n = BEAT_TABLE[int'(op)*BCW +: BCW];
        if (n == '0)
            n = BCW'(1);
        else if (n > BCW'(MAXB))
            n = BCW'(MAXB);
        return n;
    endfunction

    always_comb begin
        st_d   = st_q;
        cmp_v  = 1'b0;
        idx_d  = st_q.cnt[wr_ctx];
        op_d   = st_q.op[wr_ctx];
        need_d = st_q.need[wr_ctx];
        nxt_d  = '0;
        if (wr_en) begin
            if (st_q.cnt[wr_ctx] == '0) begin
                op_d   = wr_data[OPC_W-1:0];
                need_d = lookup_need(wr_data[OPC_W-1:0]);
                for (int k = 0; k < MAXB; k++) begin
                    st_d.beat[wr_ctx][k] = '0;
                end
            end
            st_d.op[wr_ctx]   = op_d;
            st_d.need[wr_ctx] = need_d;
            st_d.beat[wr_ctx][idx_d[BIDX_W-1:0]] = wr_data;
            nxt_d = idx_d + BCW'(1);
            if (nxt_d >= need_d) begin
                cmp_v = 1'b1;
                st_d.cnt[wr_ctx] = '0;
            end else begin
                st_d.cnt[wr_ctx] = nxt_d;
            end
        end
        cmp_op  = op_d;
        cmp_ctx = wr_ctx;
        for (int k = 0; k < MAXB; k++) begin
            cmp_data[k*DW +: DW] = st_d.beat[wr_ctx][k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCTX; c++) begin
                st_q.cnt[c]  <= '0;
                st_q.need[c] <= '0;
                st_q.op[c]   <= '0;
                for (int k = 0; k < MAXB; k++) begin
                    st_q.beat[c][k] <= '0;
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cmdbuf_issue.sv
module cmdbuf_issue #(
    parameter int PW = 132
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  logic [PW-1:0] in_pl,
    input  logic          out_ready,
    output logic          out_v,
    output logic [PW-1:0] out_pl,
    output logic          busy
);
    typedef struct packed {
        logic          out_v;
        logic          skid_v;
        logic [PW-1:0] out_pl;
        logic [PW-1:0] skid_pl;
    } iss_st_t;

    iss_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.out_v && out_ready) begin
            if (st_q.skid_v) begin
                st_d.out_pl  = st_q.skid_pl;
                st_d.skid_v  = 1'b0;
                st_d.skid_pl = '0;
            end else begin
                st_d.out_v  = in_v;
                st_d.out_pl = in_v ? in_pl : '0;
            end
        end else if (!st_q.out_v) begin
            st_d.out_v  = in_v;
            st_d.out_pl = in_v ? in_pl : '0;
        end else if (in_v && !st_q.skid_v) begin
            st_d.skid_v  = 1'b1;
            st_d.skid_pl = in_pl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_v  = st_q.out_v;
    assign out_pl = st_q.out_pl;
    assign busy   = st_q.skid_v;

endmodule

// File: rtl/cmdbuf_resbuf.sv
module cmdbuf_resbuf #(
    parameter int NCTX   = 4,
    parameter int RW     = 2,
    parameter int DW     = 32,
    parameter int CTX_W  = 2,
    parameter int WORD_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_we,
    input  logic [CTX_W-1:0]  res_ctx,
    input  logic [WORD_W-1:0] res_word,
    input  logic [DW-1:0]     res_data,
    input  logic              rd_en,
    input  logic              rd_status,
    input  logic [CTX_W-1:0]  rd_ctx,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    output logic [NCTX-1:0]   done_flags
);
    localparam int SLOTS = NCTX * RW;
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(RW - 1);

    typedef struct {
        logic [DW-1:0]   mem [SLOTS];
        logic [NCTX-1:0] done;
        logic            p1_v;
        logic [DW-1:0]   p1_d;
        logic            p2_v;
        logic [DW-1:0]   p2_d;
    } rb_st_t;

    rb_st_t st_q, st_d;

    logic [DW-1:0] status_word;
    logic [DW-1:0] pick_word;

    always_comb begin
        status_word = '0;
        status_word[NCTX-1:0] = st_q.done;
        pick_word = rd_status ? status_word : st_q.mem[{rd_ctx, rd_word}];

        st_d      = st_q;
        st_d.p1_v = rd_en;
        st_d.p1_d = rd_en ? pick_word : '0;
        st_d.p2_v = st_q.p1_v;
        st_d.p2_d = st_q.p1_d;

        if (rd_en && !rd_status && (rd_word == LAST_WORD)) begin
            st_d.done[rd_ctx] = 1'b0;
        end
        if (res_we) begin
            st_d.mem[{res_ctx, res_word}] = res_data;
            if (res_word == LAST_WORD) begin
                st_d.done[res_ctx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                st_q.mem[i] <= '0;
            end
            st_q.done <= '0;
            st_q.p1_v <= 1'b0;
            st_q.p1_d <= '0;
            st_q.p2_v <= 1'b0;
            st_q.p2_d <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.p2_d;
    assign rd_valid   = st_q.p2_v;
    assign done_flags = st_q.done;

endmodule

// File: rtl/cmdbuf_front.sv
module cmdbuf_front #(
    parameter int NCTX  = 4,
    parameter int DW    = 32,
    parameter int RW    = 2,
    parameter int MAXB  = 4,
    parameter int OPC_W = 2,
    parameter logic [(2**OPC_W)*cmdbuf_pkg::cnt_width(MAXB)-1:0] BEAT_TABLE = {3'd4, 3'd3, 3'd2, 3'd1},
    localparam int CTX_W  = cmdbuf_pkg::idx_width(NCTX),
    localparam int WORD_W = cmdbuf_pkg::idx_width(RW),
    localparam int ADDR_W = 1 + CTX_W + WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                bus_rvalid,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [OPC_W-1:0]    req_op,
    output logic [CTX_W-1:0]    req_ctx,
    output logic [MAXB*DW-1:0]  req_data,
    output logic                busy,
    input  logic                res_we,
    input  logic [CTX_W-1:0]    res_ctx,
    input  logic [WORD_W-1:0]   res_word,
    input  logic [DW-1:0]       res_data
);
    localparam int BCW = cmdbuf_pkg::cnt_width(MAXB);
    localparam int PW  = OPC_W + CTX_W + MAXB * DW;

    cmdbuf_pkg::space_e  addr_space;
    logic [CTX_W-1:0]    addr_ctx;
    logic [WORD_W-1:0]   addr_word;
    logic                wr_ok;
    logic                cmp_v;
    logic [OPC_W-1:0]    cmp_op;
    logic [CTX_W-1:0]    cmp_ctx;
    logic [MAXB*DW-1:0]  cmp_data;
    logic [PW-1:0]       out_pl;
    logic [NCTX-1:0]     done_vec;

    assign addr_space = cmdbuf_pkg::space_e'(bus_addr[ADDR_W-1]);
    assign addr_ctx   = bus_addr[WORD_W +: CTX_W];
    assign addr_word  = bus_addr[WORD_W-1:0];
    assign wr_ok      = bus_we && (addr_space == cmdbuf_pkg::SPACE_SLOT) && !busy;

    cmdbuf_assembler #(
        .NCTX(NCTX), .DW(DW), .MAXB(MAXB), .OPC_W(OPC_W),
        .CTX_W(CTX_W), .BCW(BCW), .BEAT_TABLE(BEAT_TABLE)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_ctx   (addr_ctx),
        .wr_data  (bus_wdata),
        .cmp_v    (cmp_v),
        .cmp_op   (cmp_op),
        .cmp_ctx  (cmp_ctx),
        .cmp_data (cmp_data)
    );

    cmdbuf_issue #(.PW(PW)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_v      (cmp_v),
        .in_pl     ({cmp_op, cmp_ctx, cmp_data}),
        .out_ready (req_ready),
        .out_v     (req_valid),
        .out_pl    (out_pl),
        .busy      (busy)
    );

    assign {req_op, req_ctx, req_data} = out_pl;

    cmdbuf_resbuf #(
        .NCTX(NCTX), .RW(RW), .DW(DW), .CTX_W(CTX_W), .WORD_W(WORD_W)
    ) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_we     (res_we),
        .res_ctx    (res_ctx),
        .res_word   (res_word),
        .res_data   (res_data),
        .rd_en      (bus_re),
        .rd_status  (addr_space == cmdbuf_pkg::SPACE_STATUS),
        .rd_ctx     (addr_ctx),
        .rd_word    (addr_word),
        .rd_data    (bus_rdata),
        .rd_valid   (bus_rvalid),
        .done_flags (done_vec)
    );

endmodule

// File: rtl/cmdbuf_front_chk.sv
module cmdbuf_front_chk #(
    parameter int NCTX   = 4,
    parameter int RW     = 2,
    parameter int OPC_W  = 2,
    parameter int CTX_W  = 2,
    parameter int WORD_W = 1,
    parameter int PDW    = 128,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rvalid,
    input logic              req_valid,
    input logic              req_ready,
    input logic [OPC_W-1:0]  req_op,
    input logic [CTX_W-1:0]  req_ctx,
    input logic [PDW-1:0]    req_data,
    input logic              busy,
    input logic              res_we,
    input logic [CTX_W-1:0]  res_ctx,
    input logic [WORD_W-1:0] res_word,
    input logic [NCTX-1:0]   done_vec
);
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(RW - 1);

    logic [CTX_W-1:0] a_ctx;
    logic             rd_last;
    logic             set_same;

    assign a_ctx    = bus_addr[WORD_W +: CTX_W];
    assign rd_last  = bus_re && !bus_addr[ADDR_W-1] && (bus_addr[WORD_W-1:0] == LAST_WORD);
    assign set_same = res_we && (res_word == LAST_WORD) && (res_ctx == a_ctx);

    assert_hold_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_ctx) && $stable(req_data));

    assert_busy_after_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid) && !$past(req_ready));

    assert_busy_has_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> req_valid);

    assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> ##1 bus_rvalid);

    assert_no_stray_rvalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> ##1 !bus_rvalid);

    assert_done_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_we && (res_word == LAST_WORD) |=> done_vec[$past(res_ctx)]);

    assert_done_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last && !set_same |=> !done_vec[$past(a_ctx)]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last && set_same |=> done_vec[$past(a_ctx)]);

endmodule

bind cmdbuf_front cmdbuf_front_chk #(
    .NCTX(NCTX), .RW(RW), .OPC_W(OPC_W), .CTX_W(CTX_W),
    .WORD_W(WORD_W), .PDW(MAXB*DW), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_re     (bus_re),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_ctx    (req_ctx),
    .req_data   (req_data),
    .busy       (busy),
    .res_we     (res_we),
    .res_ctx    (res_ctx),
    .res_word   (res_word),
    .done_vec   (done_vec)
);

// File: tb/cmdbuf_front_tb.sv
module cmdbuf_front_tb;
    localparam int NCTX = 4, DW = 32, RW = 2, MAXB = 4, OPC_W = 2;
    localparam int CTX_W = 2, WORD_W = 1, ADDR_W = 4;
    localparam int PW = OPC_W + CTX_W + MAXB * DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic bus_rvalid, req_valid, busy;
    logic req_ready = 1'b0;
    logic [OPC_W-1:0] req_op;
    logic [CTX_W-1:0] req_ctx;
    logic [MAXB*DW-1:0] req_data;
    logic res_we = 1'b0;
    logic [CTX_W-1:0] res_ctx = '0;
    logic [WORD_W-1:0] res_word = '0;
    logic [DW-1:0] res_data = '0;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;
    int rmode = 1;

    logic [DW-1:0] m_beats [NCTX][MAXB];
    int m_cnt [NCTX];
    int m_need [NCTX];
    logic [OPC_W-1:0] m_op [NCTX];
    logic [DW-1:0] m_res [NCTX][RW];
    bit m_done [NCTX];
    logic [PW-1:0] expq [$];

    cmdbuf_front u_dut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] status_exp();
        logic [DW-1:0] s = '0;
        for (int c = 0; c < NCTX; c++) s[c] = m_done[c];
        return s;
    endfunction

    function automatic logic [PW-1:0] pack_req(input int c);
        logic [MAXB*DW-1:0] d = '0;
        for (int k = 0; k < MAXB; k++) d[k*DW +: DW] = m_beats[c][k];
        return {m_op[c], CTX_W'(c), d};
    endfunction

    // downstream model: ready chosen at negedge, handshake checked in same process
    always @(negedge clk) begin
        case (rmode)
            0: req_ready = 1'($urandom_range(0, 1));
            1: req_ready = 1'b0;
            default: req_ready = 1'b1;
        endcase
        if (rst_n && req_valid && req_ready) begin
            if (expq.size() == 0) begin
                chk("R2 unexpected request", {req_op, req_ctx, req_data}, '0);
            end else begin
                chk("R2 R5 R6 request payload", {req_op, req_ctx, req_data}, expq.pop_front());
            end
        end
    end

    task automatic set_mode(input int m);
        @(posedge clk);
        #2 rmode = m;
    endtask

    task automatic host_write(input int c, input logic [DW-1:0] d, input bit sp);
        @(negedge clk);
        if (!busy && !sp) begin
            if (m_cnt[c] == 0) begin
                m_op[c] = d[OPC_W-1:0];
                m_need[c] = int'(d[OPC_W-1:0]) + 1;
                for (int k = 0; k < MAXB; k++) m_beats[c][k] = '0;
            end
            m_beats[c][m_cnt[c]] = d;
            m_cnt[c]++;
            if (m_cnt[c] == m_need[c]) begin
                expq.push_back(pack_req(c));
                m_cnt[c] = 0;
            end
        end
        bus_we = 1'b1;
        bus_addr = {sp, CTX_W'(c), WORD_W'($urandom_range(0, 1))};
        bus_wdata = d;
        @(posedge clk);
        #2 bus_we = 1'b0;
    endtask

    task automatic result_write(input int c, input int w, input logic [DW-1:0] d);
        @(negedge clk);
        m_res[c][w] = d;
        if (w == RW - 1) m_done[c] = 1'b1;
        res_we = 1'b1; res_ctx = CTX_W'(c); res_word = WORD_W'(w); res_data = d;
        @(posedge clk);
        #2 res_we = 1'b0;
    endtask

    task automatic host_read(input bit sp, input int c, input int w, input string tag);
        logic [DW-1:0] exp;
        @(negedge clk);
        exp = sp ? status_exp() : m_res[c][w];
        if (!sp && w == RW - 1) m_done[c] = 1'b0;
        bus_re = 1'b1; bus_addr = {sp, CTX_W'(c), WORD_W'(w)};
        @(posedge clk);
        #2 bus_re = 1'b0;
        @(negedge clk);
        chk({tag, " R8 rvalid early"}, PW'(bus_rvalid), '0);
        @(negedge clk);
        chk(tag, PW'({bus_rvalid, bus_rdata}), PW'({1'b1, exp}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R1 watchdog expired actual=hung expected=done");
            summary();
        end
    end

    initial begin
        logic [DW-1:0] old_w;
        void'($urandom(32'd2024));
        for (int c = 0; c < NCTX; c++) begin
            m_cnt[c] = 0; m_need[c] = 1; m_op[c] = '0; m_done[c] = 1'b0;
            for (int k = 0; k < MAXB; k++) m_beats[c][k] = '0;
            for (int w = 0; w < RW; w++) m_res[c][w] = '0;
        end
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", PW'({req_valid, busy, bus_rvalid, bus_rdata}), '0);
        host_read(1'b1, 0, 0, "R1 status after reset");

        // R2 R3: three-beat command, stalled so it can be inspected
        host_write(1, 32'hAAAA_0002, 1'b0);
        host_write(1, 32'h1111_2222, 1'b0);
        @(negedge clk);
        chk("R3 no request before last beat", PW'(req_valid), '0);
        host_write(1, 32'h3333_4444, 1'b0);
        @(negedge clk);
        chk("R3 request after last beat", PW'(req_valid), PW'(1));
        chk("R2 payload lanes", {req_op, req_ctx, req_data}, expq[0]);
        set_mode(2);
        repeat (3) @(negedge clk);
        chk("R2 single issue", PW'(expq.size()), '0);

        // R4 interleaved contexts plus ignored status-space write
        host_write(0, 32'h0000_0101, 1'b0);
        host_write(3, 32'h0000_0303, 1'b0);
        host_write(0, 32'h0000_0F0F, 1'b1);
        host_write(3, 32'h5555_0000, 1'b0);
        host_write(0, 32'hBEEF_0000, 1'b0);
        host_write(3, 32'h6666_0000, 1'b0);
        host_write(3, 32'h7777_0000, 1'b0);
        repeat (3) @(negedge clk);
        chk("R4 interleave drained", PW'(expq.size()), '0);

        // R6 R7 skid and busy
        set_mode(1);
        host_write(2, 32'h0000_1000, 1'b0);
        host_write(0, 32'h0000_2000, 1'b0);
        @(negedge clk);
        chk("R6 busy raised", PW'(busy), PW'(1));
        host_write(1, 32'h0000_3000, 1'b0);
        host_write(3, 32'h0000_4001, 1'b0);
        set_mode(2);
        repeat (4) @(negedge clk);
        chk("R6 busy cleared", PW'(busy), '0);
        chk("R7 ignored writes issued nothing", PW'(expq.size()), '0);
        host_write(3, 32'h0000_5000, 1'b0);
        repeat (3) @(negedge clk);
        chk("R7 dropped beat not counted", PW'(expq.size()), '0);

        // R8 R9 R10 result buffer
        result_write(2, 0, 32'hCAFE_0000);
        result_write(2, 1, 32'hCAFE_0001);
        host_read(1'b1, 0, 0, "R9 status set");
        host_read(1'b0, 2, 0, "R8 word0");
        host_read(1'b1, 0, 0, "R10 status kept after word0");
        host_read(1'b0, 2, 1, "R8 word1");
        host_read(1'b1, 0, 0, "R10 status cleared");

        // R11 collision of clear and set
        result_write(1, 1, 32'h0123_4567);
        old_w = m_res[1][1];
        @(negedge clk);
        bus_re = 1'b1; bus_addr = {1'b0, CTX_W'(1), WORD_W'(1)};
        res_we = 1'b1; res_ctx = CTX_W'(1); res_word = WORD_W'(1); res_data = 32'h89AB_CDEF;
        m_res[1][1] = 32'h89AB_CDEF; m_done[1] = 1'b1;
        @(posedge clk);
        #2 begin bus_re = 1'b0; res_we = 1'b0; end
        @(negedge clk);
        @(negedge clk);
        chk("R11 read returns old word", PW'({bus_rvalid, bus_rdata}), PW'({1'b1, old_w}));
        host_read(1'b1, 0, 0, "R11 done stays set");
        host_read(1'b0, 1, 1, "R11 new word");

        // random mix
        set_mode(0);
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 6)
                host_write($urandom_range(0, NCTX-1), $urandom, ($urandom_range(0, 9) == 0));
            else if (r < 8)
                result_write($urandom_range(0, NCTX-1), $urandom_range(0, RW-1), $urandom);
            else
                host_read(1'($urandom_range(0, 1)), $urandom_range(0, NCTX-1),
                          $urandom_range(0, RW-1), "R8 R9 R10 random read");
        end
        set_mode(2);
        repeat (10) @(negedge clk);
        chk("R6 random drain", PW'(expq.size()), '0);
        summary();
    end

endmodule